// File: doc/BRIEF.md
# Axis Threshold Interrupt Generator

This block watches a stream of signed three-axis samples, one sample per cycle in which `sampleValid` is high. For every axis it flags a high event when the sample lies above a programmable magnitude and a low event when it lies below the negated magnitude. Six enable bits pick which of these events count. Two mode bits then choose how the enabled events form a condition. Two modes use a plain OR or AND of the events. The other two modes are orientation detectors, one for entering a zone and one for staying in it.

The condition must hold for a programmable number of consecutive samples before the interrupt rises. On release the interrupt can fall at once, or it can wait for the same number of non-matching samples. In latched operation the interrupt and the source flags stay frozen until a source-register read. Configuration arrives on plain input ports and is sampled on every clock.

Top module: `axisThresholdIrq`

## Requirements
- R1: After reset `irqOut` is 0 and `srcReg` is 0.
- R2: Event bits are computed per axis. A high event means sample > `cfgThreshold`. A low event means sample < -`cfgThreshold`. A sample equal to ±threshold raises no event. Enable and flag bit order is 0 XL, 1 XH, 2 YL, 3 YH, 4 ZL, 5 ZH. With `cfgMode` = 00 the condition is the OR of the enabled events.
- R3: With `cfgMode` = 10 the condition is the AND of the enabled events. It is false when no event is enabled.
- R4: With `cfgMode` = 01 the condition holds only on a valid sample that lies in a known zone when the previous valid sample did not. A known zone means exactly one axis exceeds the threshold in magnitude and that axis's event is enabled. The previous sample counts as outside any zone after reset.
- R5: With `cfgMode` = 11 the condition holds on every valid sample that lies in a known zone.
- R6: A counter tracks consecutive valid samples with the condition true, saturating at 127. A false valid sample resets it. The interrupt rises on the valid sample at which the count reaches max(`cfgDuration`,1).
- R7: Without latching, `cfgWait` = 0 makes the interrupt fall on the first valid sample with a false condition. With `cfgWait` = 1 it falls only when the number of consecutive false valid samples reaches max(`cfgDuration`,1). A true sample during that wait restarts the release count.
- R8: With `cfgLatch` = 1 a raised interrupt stays high until a cycle with `srcRead` = 1. That cycle clears it. `srcRead` has no effect when `cfgLatch` = 0.
- R9: `srcReg` bit 6 equals the interrupt state. Bits 5:0 hold the enabled events of the latest valid sample. In latched operation they are frozen while the interrupt is held, and they refresh on the first valid sample after a read.
- R10: If a read and a qualifying valid sample fall in the same cycle, the interrupt stays high and the flags take that sample's events.
- R11: A cycle without `sampleValid` changes nothing except the latched clear of R8. No counter advances and no flag changes.
- R12: Outputs are registered. The effect of a sample appears on the outputs after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleValid | input | 1 | Sample strobe |
| sampleX | input | W | Signed X sample |
| sampleY | input | W | Signed Y sample |
| sampleZ | input | W | Signed Z sample |
| cfgEnable | input | 6 | Event enables (bit order of R2) |
| cfgMode | input | 2 | 00 OR, 10 AND, 01 zone entry, 11 zone presence |
| cfgThreshold | input | 7 | Unsigned threshold magnitude |
| cfgDuration | input | 7 | Minimum consecutive samples |
| cfgWait | input | 1 | Delay release by the duration |
| cfgLatch | input | 1 | Hold interrupt until read |
| srcRead | input | 1 | Source register read strobe |
| irqOut | output | 1 | Interrupt output |
| srcReg | output | 7 | {active, ZH, ZL, YH, YL, XH, XL} |

## Verification
A source-register read can land in the same cycle as a valid sample that qualifies the condition. In that cycle the clear and the set of the latched interrupt compete. The random phase raises reads on about a tenth of cycles while samples flow. A directed case places a read exactly on a qualifying sample that carries different events from the held flags. The expected outcome is that the interrupt survives and the flags show the new sample. A read on a cycle without a sample is then expected to drop the interrupt and leave the flags unchanged.

// File: rtl/axisIrqPkg.sv
package axisIrqPkg;
  localparam int EVT_N = 6;
  localparam int CNT_W = 7;

  typedef enum logic [1:0] {
    MODE_OR   = 2'b00,
    MODE_MOVE = 2'b01,
    MODE_AND  = 2'b10,
    MODE_POS  = 2'b11
  } irqMode_e;

  typedef struct packed {
    logic flagLoad;
    logic zoneLoad;
  } ctrlStrobe_t;
endpackage

// File: rtl/axisIrqDatapath.sv
module axisIrqDatapath
  import axisIrqPkg::*;
#(
  parameter int W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3*W-1:0]    sampleBus,
  input  logic [EVT_N-1:0]  cfgEnable,
  input  logic [1:0]        cfgMode,
  input  logic [CNT_W-1:0]  cfgThreshold,
  input  ctrlStrobe_t       strobe,
  output logic              cond,
  output logic [EVT_N-1:0]  flags
);
  localparam int EXT_W = W + 1;

  logic [EVT_N-1:0] evt;
  logic [2:0]       magAbove;
  logic             prevKnown;
  logic             known;
  logic signed [EXT_W-1:0] thrPos;
  logic signed [EXT_W-1:0] thrNeg;

  assign thrPos = $signed({{(EXT_W-CNT_W){1'b0}}, cfgThreshold});
  assign thrNeg = -thrPos;

  for (genvar a = 0; a < 3; a++) begin : g_axis
    logic [W-1:0]            axVal;
    logic signed [EXT_W-1:0] axExt;
    assign axVal = sampleBus[a*W +: W];
    assign axExt = $signed({axVal[W-1], axVal});
    assign evt[2*a]     = axExt < thrNeg;
    assign evt[2*a + 1] = axExt > thrPos;
    assign magAbove[a]  = evt[2*a] | evt[2*a + 1];
  end

  logic [EVT_N-1:0] evtEn;
  assign evtEn = evt & cfgEnable;
  assign known = $onehot(magAbove) && (evtEn != '0);

  always_comb begin
    unique case (irqMode_e'(cfgMode))
      MODE_OR:   cond = |evtEn;
      MODE_AND:  cond = (cfgEnable != '0) && (&(evt | ~cfgEnable));
      MODE_MOVE: cond = known && !prevKnown;
      MODE_POS:  cond = known;
      default:   cond = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags     <= '0;
      prevKnown <= 1'b0;
    end else begin
      if (strobe.flagLoad) flags <= evtEn;
      if (strobe.zoneLoad) prevKnown <= known;
    end
  end
endmodule

// File: rtl/axisIrqControl.sv
module axisIrqControl
  import axisIrqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic             srcRead,
  input  logic             cond,
  input  logic [CNT_W-1:0] cfgDuration,
  input  logic             cfgWait,
  input  logic             cfgLatch,
  output ctrlStrobe_t      strobe,
  output logic             active
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] hitCnt, relCnt, hitNext, relNext, durEff;
  logic             qual, activeNext, held;

  assign durEff  = (cfgDuration == '0) ? CNT_W'(1) : cfgDuration;
  assign hitNext = !cond ? '0 : (hitCnt == CNT_MAX ? CNT_MAX : hitCnt + 1'b1);
  assign relNext = cond ? '0 : (relCnt == CNT_MAX ? CNT_MAX : relCnt + 1'b1);
  assign qual    = cond && (hitNext >= durEff);
  assign held    = cfgLatch && active && !srcRead;

  always_comb begin
    if (!sampleValid) begin
      activeNext = (cfgLatch && srcRead) ? 1'b0 : active;
    end else if (cfgLatch) begin
      activeNext = qual || (active && !srcRead);
    end else if (cfgWait) begin
      activeNext = qual || (active && (relNext < durEff));
    end else begin
      activeNext = qual || (active && cond);
    end
  end

  assign strobe.flagLoad = sampleValid && !held;
  assign strobe.zoneLoad = sampleValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitCnt <= '0;
      relCnt <= '0;
      active <= 1'b0;
    end else begin
      active <= activeNext;
      if (sampleValid) begin
        hitCnt <= hitNext;
        relCnt <= relNext;
      end
    end
  end
endmodule

// File: rtl/axisThresholdIrq.sv
module axisThresholdIrq
  import axisIrqPkg::*;
#(
  parameter int W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleValid,
  input  logic signed [W-1:0]  sampleX,
  input  logic signed [W-1:0]  sampleY,
  input  logic signed [W-1:0]  sampleZ,
  input  logic [5:0]           cfgEnable,
  input  logic [1:0]           cfgMode,
  input  logic [6:0]           cfgThreshold,
  input  logic [6:0]           cfgDuration,
  input  logic                 cfgWait,
  input  logic                 cfgLatch,
  input  logic                 srcRead,
  output logic                 irqOut,
  output logic [6:0]           srcReg
);
  ctrlStrobe_t      strobe;
  logic             cond, active;
  logic [EVT_N-1:0] flags;

  axisIrqDatapath #(.W(W)) dp_i (
    .clk(clk), .rstN(rstN),
    .sampleBus({sampleZ, sampleY, sampleX}),
    .cfgEnable(cfgEnable), .cfgMode(cfgMode), .cfgThreshold(cfgThreshold),
    .strobe(strobe), .cond(cond), .flags(flags)
  );

  axisIrqControl ctl_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .srcRead(srcRead),
    .cond(cond), .cfgDuration(cfgDuration), .cfgWait(cfgWait),
    .cfgLatch(cfgLatch), .strobe(strobe), .active(active)
  );

  assign irqOut = active;
  assign srcReg = {active, flags};
endmodule

// File: rtl/axisIrqChecker.sv
module axisIrqChecker (
  input logic       clk,
  input logic       rstN,
  input logic       sampleValid,
  input logic [5:0] cfgEnable,
  input logic [1:0] cfgMode,
  input logic       cfgWait,
  input logic       cfgLatch,
  input logic       srcRead,
  input logic       irqOut,
  input logic [6:0] srcReg
);
  // R11: idle cycle without read leaves outputs alone
  a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleValid && !srcRead) |=> ($stable(irqOut) && $stable(srcReg)));

  // R8: latched interrupt holds until read
  a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLatch && irqOut && !srcRead) |=> irqOut);

  // R8: read without sample clears latched interrupt
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLatch && srcRead && !sampleValid) |=> !irqOut);

  // R3: nothing enabled never raises
  a_r3_no_enable_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!irqOut && cfgEnable == 6'd0) |=> !irqOut);

  // R7: immediate release in OR mode when no flag is set
  a_r7_fast_release: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !cfgLatch && !cfgWait && cfgMode == 2'b00)
      |=> (srcReg[5:0] != 6'd0 || !irqOut));
endmodule

bind axisThresholdIrq axisIrqChecker chk_i (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .cfgEnable(cfgEnable),
  .cfgMode(cfgMode), .cfgWait(cfgWait), .cfgLatch(cfgLatch),
  .srcRead(srcRead), .irqOut(irqOut), .srcReg(srcReg)
);

// File: tb/axisThresholdIrq_tb.sv
module axisThresholdIrq_tb_top;
  localparam int W = 12;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rstN = 0;
  logic sampleValid = 0, srcRead = 0, cfgWait = 0, cfgLatch = 0;
  logic signed [W-1:0] sampleX = 0, sampleY = 0, sampleZ = 0;
  logic [5:0] cfgEnable = 0;
  logic [1:0] cfgMode = 0;
  logic [6:0] cfgThreshold = 0, cfgDuration = 0;
  logic irqOut;
  logic [6:0] srcReg;

  int checkCount = 0, failCount = 0;

  // model state
  int  mHit = 0, mRel = 0;
  bit  mActive = 0, mPrevKnown = 0;
  logic [5:0] mFlags = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  axisThresholdIrq #(.W(W)) dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sampleX(sampleX), .sampleY(sampleY), .sampleZ(sampleZ),
    .cfgEnable(cfgEnable), .cfgMode(cfgMode), .cfgThreshold(cfgThreshold),
    .cfgDuration(cfgDuration), .cfgWait(cfgWait), .cfgLatch(cfgLatch),
    .srcRead(srcRead), .irqOut(irqOut), .srcReg(srcReg)
  );

  task automatic checkVal(string tag, int actual, int expected);
    checkCount++;
    if (actual != expected) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  function automatic string modeTag();
    if (cfgLatch) return "R8";
    if (cfgWait) return "R7";
    case (cfgMode)
      2'b01: return "R4";
      2'b11: return "R5";
      2'b10: return "R3";
      default: return "R2";
    endcase
  endfunction

  // reference model from the requirements
  task automatic modelStep(bit v, int x, int y, int z, bit rd);
    int thr = cfgThreshold;
    int durE = (cfgDuration == 0) ? 1 : cfgDuration;
    logic [5:0] ev, evEn;
    bit known, cond, qual, nextAct;
    int hitN, relN, magCnt;
    if (!v) begin
      if (cfgLatch && rd) mActive = 0;
      return;
    end
    ev[0] = x < -thr; ev[1] = x > thr;
    ev[2] = y < -thr; ev[3] = y > thr;
    ev[4] = z < -thr; ev[5] = z > thr;
    evEn = ev & cfgEnable;
    magCnt = (ev[0] | ev[1]) + (ev[2] | ev[3]) + (ev[4] | ev[5]);
    known = (magCnt == 1) && (evEn != 0);
    case (cfgMode)
      2'b00: cond = evEn != 0;
      2'b10: cond = (cfgEnable != 0) && ((ev & cfgEnable) == cfgEnable);
      2'b01: cond = known && !mPrevKnown;
      default: cond = known;
    endcase
    hitN = cond ? ((mHit == 127) ? 127 : mHit + 1) : 0;
    relN = cond ? 0 : ((mRel == 127) ? 127 : mRel + 1);
    qual = cond && (hitN >= durE);
    if (cfgLatch) nextAct = qual || (mActive && !rd);
    else if (cfgWait) nextAct = qual || (mActive && (relN < durE));
    else nextAct = qual || (mActive && cond);
    if (!(cfgLatch && mActive && !rd)) mFlags = evEn;
    mActive = nextAct;
    mHit = hitN; mRel = relN; mPrevKnown = known;
  endtask

  task automatic doStep(bit v, int x, int y, int z, bit rd);
    sampleValid = v; sampleX = W'(x); sampleY = W'(y); sampleZ = W'(z); srcRead = rd;
    modelStep(v, x, y, z, rd);
    @(negedge clk);
    checkVal($sformatf("%s/R12 irqOut", modeTag()), irqOut, mActive);
    checkVal("R9 srcReg", srcReg, {mActive, mFlags});
  endtask

  task automatic setCfg(int mode, int en, int thr, int dur, bit wt, bit lt);
    cfgMode = 2'(mode); cfgEnable = 6'(en); cfgThreshold = 7'(thr);
    cfgDuration = 7'(dur); cfgWait = wt; cfgLatch = lt;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failCount++; checkCount++;
    $display("FAIL R12 watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    checkVal("R1 irqOut reset", irqOut, 0);
    checkVal("R1 srcReg reset", srcReg, 0);
    rstN = 1;
    @(negedge clk);

    // R2 threshold boundaries, OR mode
    setCfg(0, 6'h3f, 10, 0, 0, 0);
    doStep(1, 10, 0, 0, 0);  checkVal("R2 equal high", srcReg, 7'h00);
    doStep(1, 11, 0, 0, 0);  checkVal("R2 above high", srcReg, 7'h42);
    doStep(1, -10, 0, 0, 0); checkVal("R2 equal low", srcReg, 7'h00);
    doStep(1, 0, -11, 0, 0); checkVal("R2 below low", srcReg, 7'h44);
    // R11 idle cycle ignores sample value
    doStep(0, 0, 0, 0, 0);   checkVal("R11 idle hold", srcReg, 7'h44);
    doStep(1, 0, 0, 0, 1);   checkVal("R8 read ignored unlatched", irqOut, 0);

    // R6 duration 3
    setCfg(0, 6'h02, 10, 3, 0, 0);
    doStep(1, 20, 0, 0, 0); checkVal("R6 count1", irqOut, 0);
    doStep(1, 20, 0, 0, 0); checkVal("R6 count2", irqOut, 0);
    doStep(1, 20, 0, 0, 0); checkVal("R6 count3", irqOut, 1);
    // R7 wait release
    cfgWait = 1;
    doStep(1, 0, 0, 0, 0); checkVal("R7 wait1", irqOut, 1);
    doStep(1, 0, 0, 0, 0); checkVal("R7 wait2", irqOut, 1);
    doStep(1, 0, 0, 0, 0); checkVal("R7 wait3", irqOut, 0);

    // R10 read and qualifying sample together
    setCfg(0, 6'h02, 10, 0, 0, 1);
    doStep(1, 20, 0, 0, 0); checkVal("R8 latch set", srcReg, 7'h42);
    cfgEnable = 6'h03;
    doStep(1, 0, 0, 0, 0);  checkVal("R9 frozen flags", srcReg, 7'h42);
    doStep(1, -20, 0, 0, 1); checkVal("R10 collision", srcReg, 7'h41);
    doStep(0, 0, 0, 0, 1);  checkVal("R8 read clear", srcReg, 7'h01);

    // R4 movement pulse
    setCfg(1, 6'h3f, 10, 0, 0, 0);
    doStep(1, 0, 0, 0, 0);
    doStep(1, 0, 0, 30, 0); checkVal("R4 entry", irqOut, 1);
    doStep(1, 0, 0, 30, 0); checkVal("R4 one sample", irqOut, 0);
    // R5 position
    cfgMode = 2'b11;
    doStep(1, 0, 0, 30, 0); checkVal("R5 inside", irqOut, 1);
    doStep(1, 30, 0, 30, 0); checkVal("R5 two axes", irqOut, 0);
    // R3 AND
    setCfg(2, 6'h0a, 10, 0, 0, 0);
    doStep(1, 20, 0, 0, 0); checkVal("R3 partial", irqOut, 0);
    doStep(1, 20, 20, 0, 0); checkVal("R3 all", irqOut, 1);

    // constrained random segments
    for (int seg = 0; seg < 40; seg++) begin
      setCfg($urandom_range(0, 3),
             ($urandom_range(0, 3) == 0) ? 6'h3f : $urandom_range(0, 63),
             $urandom_range(5, 30), $urandom_range(0, 4),
             $urandom_range(0, 1), $urandom_range(0, 1));
      for (int s = 0; s < 150; s++) begin
        doStep($urandom_range(0, 3) != 0,
               int'($urandom_range(0, 80)) - 40,
               int'($urandom_range(0, 80)) - 40,
               int'($urandom_range(0, 80)) - 40,
               $urandom_range(0, 9) == 0);
      end
    end

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule